// File: doc/BRIEF.md
# Spike Address Fan-out Router

This block turns a stream of spike events into a stream of synaptic target addresses. Each incoming event is the address of the neuron that fired. The block looks that address up in a pointer table, which gives a starting index and a length into a target memory. It then walks that run of consecutive target entries and emits each stored target address on an output stream, one per cycle. The output stream goes back to the neuron array, where each address causes one post-synaptic event.

Connectivity is held entirely in the two tables, so there is no wiring inside the logic. A host write port rewrites pointer entries or target entries to reroute connections. Writes are taken only while no fan-out is in progress, and they apply from the next spike onward. While a fan-out is running, the input is held off so that waiting spikes stay upstream and none is dropped.

Top module: `spike_fanout_router`

## Requirements
- R1: After reset, `tgt_valid` is low, and `spk_ready` and `hw_ready` are high while `hw_valid` is low. Every pointer length is zero, so a spike accepted before any host write emits nothing.
- R2: When the block is idle and `hw_valid` is low, `spk_ready` is high. A spike is taken on a clock edge where `spk_valid` and `spk_ready` are both high.
- R3: For a source whose pointer entry holds start index b and length n > 0, the block emits the target memory contents at indices b, b+1, …, b+n-1 in that order. The index wraps modulo the target memory depth.
- R4: `tgt_valid` rises in the cycle after the edge that takes the spike. While `tgt_ready` stays high, one target is handed over per cycle, so n targets take exactly n cycles.
- R5: While `tgt_valid` is high and `tgt_ready` is low, `tgt_addr` holds steady. Each target is handed over exactly once.
- R6: While targets are being emitted, `spk_ready` and `hw_ready` are both low.
- R7: A spike whose pointer length is zero is consumed and emits nothing. `spk_ready` is high again in the next cycle.
- R8: `hw_ready` is high exactly when no fan-out is running. A host write wins over a spike offered in the same cycle. With `hw_sel`=0, pointer entry `hw_index[ADDR_W-1:0]` is written: the length comes from `hw_data[CNT_W-1:0]` and the start index from `hw_data[DATA_W-1:CNT_W]`. With `hw_sel`=1, target entry `hw_index` is written with `hw_data[ADDR_W-1:0]`.
- R9: A spike taken after a write has been accepted uses the rewritten entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| spk_valid | input | 1 | Spike event offered |
| spk_ready | output | 1 | Spike event can be taken |
| spk_src | input | ADDR_W | Address of the neuron that fired |
| tgt_valid | output | 1 | Target address offered |
| tgt_ready | input | 1 | Downstream takes the target |
| tgt_addr | output | ADDR_W | Synaptic target address |
| hw_valid | input | 1 | Host write request |
| hw_ready | output | 1 | Host write can be taken |
| hw_sel | input | 1 | 0 = pointer entry, 1 = target entry |
| hw_index | input | IDX_W | Entry index |
| hw_data | input | IDX_W+CNT_W | Entry contents |

## Verification
The first target is due at the first falling edge after the rising edge that takes a spike. After that, a new target is due one cycle after each handover. The end of a fan-out shows as `tgt_valid` low and `spk_ready` high at the falling edge after the last handover. The bench drives inputs and samples outputs only on falling edges, and it counts cycles from the accepting edge, so each check lands in the cycle where its result is due. A reference copy of both tables, updated on every accepted host write, supplies the expected address order. This includes a reroute between two spikes from the same source and a run that wraps past the end of the target memory.

// File: rtl/spike_fanout_router.sv
module spike_fanout_router #(
  parameter  int ADDR_W = 10,
  parameter  int IDX_W  = 11,
  parameter  int CNT_W  = 8,
  localparam int SRC_N  = 1 << ADDR_W,
  localparam int TGT_N  = 1 << IDX_W,
  localparam int DATA_W = IDX_W + CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spk_valid,
  output logic              spk_ready,
  input  logic [ADDR_W-1:0] spk_src,
  output logic              tgt_valid,
  input  logic              tgt_ready,
  output logic [ADDR_W-1:0] tgt_addr,
  input  logic              hw_valid,
  output logic              hw_ready,
  input  logic              hw_sel,
  input  logic [IDX_W-1:0]  hw_index,
  input  logic [DATA_W-1:0] hw_data
);

  logic [IDX_W-1:0]  start_tab [SRC_N];
  logic [CNT_W-1:0]  len_tab   [SRC_N];
  logic [ADDR_W-1:0] dest_mem  [TGT_N];

  logic              busy;
  logic [IDX_W-1:0]  walk;
  logic [CNT_W-1:0]  left;

  wire spk_take = spk_valid & spk_ready;
  wire hw_take  = hw_valid & hw_ready;
  wire tgt_take = tgt_valid & tgt_ready;
  wire [ADDR_W-1:0] wr_src = hw_index[ADDR_W-1:0];

  assign hw_ready  = !busy;
  assign spk_ready = !busy && !hw_valid;
  assign tgt_valid = busy;
  assign tgt_addr  = dest_mem[walk];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      walk <= '0;
      left <= '0;
    end else if (spk_take) begin
      walk <= start_tab[spk_src];
      left <= len_tab[spk_src];
      busy <= (len_tab[spk_src] != '0);
    end else if (tgt_take) begin
      walk <= walk + 1'b1;
      left <= left - 1'b1;
      if (left == CNT_W'(1)) busy <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SRC_N; i++) len_tab[i] <= '0;
    end else if (hw_take && !hw_sel) begin
      len_tab[wr_src] <= hw_data[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (hw_take && !hw_sel) start_tab[wr_src] <= hw_data[DATA_W-1:CNT_W];
    if (hw_take && hw_sel)  dest_mem[hw_index] <= hw_data[ADDR_W-1:0];
  end

endmodule

module spike_fanout_router_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              spk_valid,
  input logic              spk_ready,
  input logic              tgt_valid,
  input logic              tgt_ready,
  input logic [ADDR_W-1:0] tgt_addr,
  input logic              hw_valid,
  input logic              hw_ready
);

  p_reset_quiet_r1: assert property (@(posedge clk) !rst_n |=> !tgt_valid);

  p_hold_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_valid && !tgt_ready |=> tgt_valid && $stable(tgt_addr));

  p_input_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_valid |-> !spk_ready && !hw_ready);

  p_host_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hw_valid |-> !spk_ready);

  p_idle_open_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tgt_valid && !hw_valid |-> spk_ready && hw_ready);

  p_one_stream_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(spk_valid && spk_ready && hw_valid && hw_ready));

endmodule

bind spike_fanout_router spike_fanout_router_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .spk_valid(spk_valid), .spk_ready(spk_ready),
  .tgt_valid(tgt_valid), .tgt_ready(tgt_ready), .tgt_addr(tgt_addr),
  .hw_valid(hw_valid), .hw_ready(hw_ready)
);

// File: tb/sim_spike_fanout_router.sv
module sim_spike_fanout_router;
  localparam int ADDR_W = 10;
  localparam int IDX_W  = 11;
  localparam int CNT_W  = 8;
  localparam int DATA_W = IDX_W + CNT_W;
  localparam int TGT_N  = 1 << IDX_W;
  localparam int SRC_N  = 1 << ADDR_W;

  // kinds: 0 pointer write (a=src,b=start,c=len), 1 target write (a=idx,b=addr),
  //        2 spike with ready held high, 3 spike with ready toggling
  localparam int NOPS = 15;
  localparam int OP_K [NOPS] = '{1, 1, 1, 1, 1, 1, 0, 0, 2, 3, 2, 0, 1, 2, 3};
  localparam int OP_A [NOPS] = '{0, 1, 2, 3, 4, 5, 3, 7, 3, 7, 9, 3, 4, 3, 3};
  localparam int OP_B [NOPS] = '{100, 101, 102, 103, 104, 105, 0, 2, 0, 0, 0, 4, 999, 0, 0};
  localparam int OP_C [NOPS] = '{0, 0, 0, 0, 0, 0, 3, 4, 0, 0, 0, 2, 0, 0, 0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spk_valid = 1'b0, spk_ready;
  logic [ADDR_W-1:0] spk_src = '0;
  logic tgt_valid, tgt_ready = 1'b0;
  logic [ADDR_W-1:0] tgt_addr;
  logic hw_valid = 1'b0, hw_ready, hw_sel = 1'b0;
  logic [IDX_W-1:0] hw_index = '0;
  logic [DATA_W-1:0] hw_data = '0;

  int compared = 0, mismatched = 0;
  bit done = 1'b0;
  int ref_start [SRC_N];
  int ref_len   [SRC_N];
  int ref_dest  [TGT_N];

  always #2 clk = ~clk;

  spike_fanout_router #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .spk_valid(spk_valid), .spk_ready(spk_ready),
    .spk_src(spk_src), .tgt_valid(tgt_valid), .tgt_ready(tgt_ready),
    .tgt_addr(tgt_addr), .hw_valid(hw_valid), .hw_ready(hw_ready),
    .hw_sel(hw_sel), .hw_index(hw_index), .hw_data(hw_data)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic host_write(input bit sel, input int idx, input int data);
    @(negedge clk);
    hw_valid = 1'b1; hw_sel = sel; hw_index = IDX_W'(idx); hw_data = DATA_W'(data);
    while (!hw_ready) @(negedge clk);
    @(negedge clk);
    hw_valid = 1'b0;
    if (sel) ref_dest[idx] = data % (1 << ADDR_W);
    else begin
      ref_len[idx % SRC_N]   = data % (1 << CNT_W);
      ref_start[idx % SRC_N] = data >> CNT_W;
    end
  endtask

  task automatic spike(input int src, input bit stall);
    int n, b, got, cyc, seen;
    bit hold;
    n = ref_len[src]; b = ref_start[src];
    got = 0; cyc = 0; hold = 1'b0; seen = 0;
    @(negedge clk);
    spk_valid = 1'b1; spk_src = ADDR_W'(src);
    while (!spk_ready) @(negedge clk);
    @(negedge clk);
    spk_valid = 1'b0;
    check(tgt_valid == (n > 0), "R4 first target one cycle after accept", int'(tgt_valid), int'(n > 0));
    while (got < n && cyc < 4 * n + 8) begin
      if (hold) check(tgt_valid && int'(tgt_addr) == seen, "R5 held address", int'(tgt_addr), seen);
      check(!spk_ready && !hw_ready, "R6 inputs held off", int'(spk_ready), 0);
      tgt_ready = !stall || cyc[0];
      if (tgt_valid && tgt_ready) begin
        check(int'(tgt_addr) == ref_dest[(b + got) % TGT_N], "R3 target order",
              int'(tgt_addr), ref_dest[(b + got) % TGT_N]);
        got++; hold = 1'b0;
      end else if (tgt_valid) begin
        hold = 1'b1; seen = int'(tgt_addr);
      end
      cyc++;
      @(negedge clk);
    end
    tgt_ready = 1'b0;
    check(got == n, "R3 target count", got, n);
    if (!stall) check(cyc == n, "R4 one target per cycle", cyc, n);
    check(!tgt_valid && spk_ready, "R7 idle after fan-out", int'(tgt_valid), 0);
  endtask

  initial begin
    for (int i = 0; i < SRC_N; i++) begin ref_len[i] = 0; ref_start[i] = 0; end
    for (int i = 0; i < TGT_N; i++) ref_dest[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!tgt_valid, "R1 no target after reset", int'(tgt_valid), 0);
    check(spk_ready && hw_ready, "R1 ready after reset", int'(spk_ready), 1);
    spike(5, 1'b0);   // R1 / R7: all lengths zero after reset

    for (int i = 0; i < NOPS; i++) begin
      case (OP_K[i])
        0: host_write(1'b0, OP_A[i], (OP_B[i] << CNT_W) | OP_C[i]);
        1: host_write(1'b1, OP_A[i], OP_B[i]);
        2: spike(OP_A[i], 1'b0);
        default: spike(OP_A[i], 1'b1);
      endcase
    end

    // R8: host write wins over a spike offered in the same cycle
    host_write(1'b1, 10, 321);
    @(negedge clk);
    hw_valid = 1'b1; hw_sel = 1'b0; hw_index = IDX_W'(20);
    hw_data = DATA_W'((10 << CNT_W) | 1);
    spk_valid = 1'b1; spk_src = ADDR_W'(20);
    #1;
    check(!spk_ready && hw_ready, "R8 host write priority", int'(spk_ready), 0);
    @(negedge clk);
    hw_valid = 1'b0; spk_valid = 1'b0;
    ref_start[20] = 10; ref_len[20] = 1;
    check(!tgt_valid, "R8 spike not taken during write", int'(tgt_valid), 0);
    spike(20, 1'b0);  // R9: new entry used at once

    // R3: run wraps past the end of the target memory
    host_write(1'b1, TGT_N - 2, 511);
    host_write(1'b1, TGT_N - 1, 512);
    host_write(1'b0, 30, ((TGT_N - 2) << CNT_W) | 4);
    spike(30, 1'b1);
    spike(30, 1'b0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule